// File: doc/BRIEF.md
# SMBus Host Controller Engine

This block is a register-programmed SMBus master. Software fills in a target address byte, a command byte and up to two data bytes through a small byte-wide register port. A single write to the host-control register then names the protocol and launches the whole transaction. The engine builds the bus sequence by itself: start, address, command, data, repeated start, read bytes with ACK or NACK, and stop. It drives SCL and SDA only through open-drain output enables and reads the wires back.

Five protocols are supported: quick command, send/receive byte, write/read byte data, write/read word data, and process call. The end of a transaction shows up as one of three sticky status flags: done, device error (missing ACK) and collision. Software clears each flag by writing a one to it. A busy indication in the control register tells software when the engine is running. An abort write stops the engine at once. The SCL rate comes from the system clock through a quarter-bit divider set by a parameter. The default of 125 gives about 100 kHz from a 50 MHz clock.

Top module: `smbus_host`

## Requirements
- R1: After reset every readable register reads 0x00, the engine is idle and both open-drain enables are deasserted.
- R2: A write to host control (offset 0x03) with bit 4 set and bit 5 clear starts a transaction whose protocol is bits 2:0: 0 quick, 1 byte, 2 byte data, 3 word data, 4 process call. Such a write while busy is ignored and the running transaction completes unchanged.
- R3: A host-control write with bit 5 set (0x20) aborts at once. The engine is idle and both enables are released on the next cycle, and no status flag is set.
- R4: Control register (offset 0x02) bit 0 reads 1 exactly while a transaction runs, and bit 1 always reads 0. Bits 7:2 are plain read/write storage.
- R5: Status (offset 0x00) bit 1 = device error, bit 2 = collision, bit 3 = done. The flags are sticky and cleared only by writing 1 to them. Other bits read 0.
- R6: The address register (offset 0x04) holds the target address in bits 7:1 and the direction in bit 0 (1 = read). Quick and byte protocols send it unchanged. The other protocols send it with bit 0 forced to 0 first, and for reads a repeated start follows with bit 0 forced to 1.
- R7: A byte-protocol write sends the command register (offset 0x05) as its only data byte. A byte-protocol read stores the received byte in data 0 (offset 0x08).
- R8: Byte-data and word protocols send the command and then data 0, and for words also data 1 (offset 0x09, high byte). Their reads place the first received byte in data 0 and the second in data 1, ACK every byte but the last and NACK the last.
- R9: A process call writes the command, data 0 and data 1. It then issues a repeated start with a read address and overwrites data 0 and data 1 with the two returned bytes.
- R10: A missing ACK on any transmitted byte ends the transfer with a stop condition, then sets the device-error flag and not done.
- R11: Protocol codes 5 to 7 set the device-error flag at once with no bus activity.
- R12: If SDA reads low while the engine releases it to send a 1 bit, the engine releases both lines, goes idle and sets the collision flag.
- R13: Each bit lasts 4*QUARTER clock cycles, and the SCL enable only changes on a quarter-period tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| scl_in | input | 1 | SCL wire level |
| sda_in | input | 1 | SDA wire level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The embedded properties check the following on every cycle:
- Both lines are released whenever the engine is idle.
- SCL moves only on divider ticks.
- An abort or an unsupported code leaves the engine idle the next cycle.
- The done flag survives everything but a write-one clear.
- Error and collision flags rise only as the engine drops busy.

The byte order on the wire, the address direction forcing, repeated starts, the ACK/NACK pattern of reads and the data returned into the data registers can only be shown by the bench. It does this with a behavioural SMBus target that logs every byte it receives and answers reads, combined with randomized transactions across all five protocols and both directions.

// File: rtl/smbus_host.sv
module smbus_host #(
  parameter int QUARTER = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int DW = (QUARTER > 1) ? $clog2(QUARTER) : 1;
  localparam logic [3:0] OP_START = 4'd0, OP_TXRAW = 4'd1, OP_TXW = 4'd2, OP_TXR = 4'd3,
                         OP_TXCMD = 4'd4, OP_TXD0 = 4'd5, OP_TXD1 = 4'd6, OP_RX0A = 4'd7,
                         OP_RX0N = 4'd8, OP_RX1N = 4'd9, OP_STOP = 4'd10;

  function automatic logic [3:0] step_op(input logic [2:0] p, input logic rd, input logic [3:0] i);
    logic [3:0] r;
    r = OP_STOP;
    case (p)
      3'd0: case (i) 4'd0: r = OP_START; 4'd1: r = OP_TXRAW; default: r = OP_STOP; endcase
      3'd1: case (i) 4'd0: r = OP_START; 4'd1: r = OP_TXRAW; 4'd2: r = rd ? OP_RX0N : OP_TXCMD;
                     default: r = OP_STOP; endcase
      3'd2: if (!rd)
              case (i) 4'd0: r = OP_START; 4'd1: r = OP_TXW; 4'd2: r = OP_TXCMD; 4'd3: r = OP_TXD0;
                       default: r = OP_STOP; endcase
            else
              case (i) 4'd0: r = OP_START; 4'd1: r = OP_TXW; 4'd2: r = OP_TXCMD; 4'd3: r = OP_START;
                       4'd4: r = OP_TXR; 4'd5: r = OP_RX0N; default: r = OP_STOP; endcase
      3'd3: if (!rd)
              case (i) 4'd0: r = OP_START; 4'd1: r = OP_TXW; 4'd2: r = OP_TXCMD; 4'd3: r = OP_TXD0;
                       4'd4: r = OP_TXD1; default: r = OP_STOP; endcase
            else
              case (i) 4'd0: r = OP_START; 4'd1: r = OP_TXW; 4'd2: r = OP_TXCMD; 4'd3: r = OP_START;
                       4'd4: r = OP_TXR; 4'd5: r = OP_RX0A; 4'd6: r = OP_RX1N; default: r = OP_STOP; endcase
      default:
              case (i) 4'd0: r = OP_START; 4'd1: r = OP_TXW; 4'd2: r = OP_TXCMD; 4'd3: r = OP_TXD0;
                       4'd4: r = OP_TXD1; 4'd5: r = OP_START; 4'd6: r = OP_TXR; 4'd7: r = OP_RX0A;
                       4'd8: r = OP_RX1N; default: r = OP_STOP; endcase
    endcase
    return r;
  endfunction

  logic [2:0] flags;
  logic [7:0] en_r, adr, cmd, d0, d1;
  logic [5:0] ctl_hi;
  logic busy, fin, nack, scl_low, sda_low;
  logic [2:0] proto;
  logic [3:0] step, bitc;
  logic [1:0] q;
  logic [DW-1:0] div;
  logic [6:0] rxsh;
  logic [7:0] txbyte;

  wire tick     = busy && (div == DW'(QUARTER - 1));
  wire [3:0] op = fin ? OP_STOP : step_op(proto, adr[0], step);
  wire is_tx    = (op >= OP_TXRAW) && (op <= OP_TXD1);
  wire is_rx    = (op >= OP_RX0A) && (op <= OP_RX1N);
  wire ack_slot = bitc[3];
  wire txbit    = txbyte[3'd7 - bitc[2:0]];
  wire wr_hc    = reg_wr && (reg_addr == 4'd3);
  wire abort    = wr_hc && reg_wdata[5];
  wire go       = wr_hc && reg_wdata[4] && !reg_wdata[5] && !busy;

  always_comb begin
    case (op)
      OP_TXRAW: txbyte = adr;
      OP_TXW:   txbyte = {adr[7:1], 1'b0};
      OP_TXR:   txbyte = {adr[7:1], 1'b1};
      OP_TXCMD: txbyte = cmd;
      OP_TXD0:  txbyte = d0;
      OP_TXD1:  txbyte = d1;
      default:  txbyte = 8'h00;
    endcase
  end

  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = {4'b0, flags, 1'b0};
      4'd1:    reg_rdata = en_r;
      4'd2:    reg_rdata = {ctl_hi, 1'b0, busy};
      4'd4:    reg_rdata = adr;
      4'd5:    reg_rdata = cmd;
      4'd8:    reg_rdata = d0;
      4'd9:    reg_rdata = d1;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign scl_oe = scl_low;
  assign sda_oe = sda_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0; en_r <= '0; adr <= '0; cmd <= '0; d0 <= '0; d1 <= '0; ctl_hi <= '0;
      busy <= 1'b0; fin <= 1'b0; nack <= 1'b0; scl_low <= 1'b0; sda_low <= 1'b0;
      proto <= '0; step <= '0; bitc <= '0; q <= '0; div <= '0; rxsh <= '0;
    end else begin
      div <= (busy && !tick) ? div + 1'b1 : '0;
      if (reg_wr)
        case (reg_addr)
          4'd0: flags  <= flags & ~reg_wdata[3:1];
          4'd1: en_r   <= reg_wdata;
          4'd2: ctl_hi <= reg_wdata[7:2];
          4'd4: adr    <= reg_wdata;
          4'd5: cmd    <= reg_wdata;
          4'd8: d0     <= reg_wdata;
          4'd9: d1     <= reg_wdata;
          default: ;
        endcase
      if (abort) begin
        busy <= 1'b0; scl_low <= 1'b0; sda_low <= 1'b0;
      end else if (go) begin
        if (reg_wdata[2:0] >= 3'd5) flags[0] <= 1'b1;
        else begin
          busy <= 1'b1; proto <= reg_wdata[2:0]; step <= '0; bitc <= '0;
          q <= '0; fin <= 1'b0; nack <= 1'b0;
        end
      end else if (tick) begin
        q <= q + 1'b1;
        case (q)
          2'd0: begin
            if (op == OP_START)     sda_low <= 1'b0;
            else if (op == OP_STOP) sda_low <= 1'b1;
            else if (is_tx)         sda_low <= !ack_slot && !txbit;
            else                    sda_low <= ack_slot && (op == OP_RX0A);
          end
          2'd1: scl_low <= 1'b0;
          2'd2: begin
            if (op == OP_START)     sda_low <= 1'b1;
            else if (op == OP_STOP) sda_low <= 1'b0;
            else if (is_tx && !ack_slot && txbit && !sda_in) begin
              busy <= 1'b0; scl_low <= 1'b0; sda_low <= 1'b0; flags[1] <= 1'b1;
            end else if (is_tx && ack_slot && sda_in) nack <= 1'b1;
            else if (is_rx && !ack_slot) begin
              rxsh <= {rxsh[5:0], sda_in};
              if (bitc == 4'd7) begin
                if (op == OP_RX1N) d1 <= {rxsh, sda_in};
                else               d0 <= {rxsh, sda_in};
              end
            end
          end
          default: begin
            if (op == OP_STOP) begin
              busy <= 1'b0;
              if (nack) flags[0] <= 1'b1;
              else      flags[2] <= 1'b1;
            end else begin
              scl_low <= 1'b1;
              if (op == OP_START) step <= step + 1'b1;
              else if (ack_slot) begin
                bitc <= '0; step <= step + 1'b1;
                if (nack) fin <= 1'b1;
              end else bitc <= bitc + 1'b1;
            end
          end
        endcase
      end
    end
  end

  a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_low && !sda_low));
  a_r13_scl_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(scl_low)) |-> $past(tick));
  a_r3_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr && reg_addr == 4'd3 && reg_wdata[5]) |-> (!busy && !scl_low && !sda_low));
  a_r11_block_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr && reg_addr == 4'd3 && reg_wdata[4] && !reg_wdata[5] && !busy && reg_wdata[2:0] >= 3'd5)
      |-> (!busy && flags[0]));
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flags[2]) && !$past(reg_wr && reg_addr == 4'd0 && reg_wdata[3])) |-> flags[2]);
  a_r12_collision_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> !busy);
  a_r10_error_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> (!busy && !scl_low && !sda_low));
endmodule

// File: tb/smbus_host_tb.sv
module smbus_host_tb_top;
  localparam int Q = 4;
  localparam logic [6:0] SLV = 7'h3A;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic [3:0] ra = '0;
  logic rw = 1'b0;
  logic [7:0] wd = '0;
  wire [7:0] rdat;
  wire scl_oe, sda_oe;
  logic slv_low = 1'b0, force_low = 1'b0;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || slv_low || force_low);

  smbus_host #(.QUARTER(Q)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(ra), .reg_wr(rw), .reg_wdata(wd), .reg_rdata(rdat),
    .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe));

  int checks = 0, errors = 0, cyc = 0;

  // behavioural SMBus target
  logic p_scl = 1'b1, p_sda = 1'b1, active = 1'b0, reading = 1'b0, addr_ok = 1'b0, rdm = 1'b0, mack = 1'b0;
  int bcnt = 0, byte_i = 0, rdi = 0, log_n = 0, act_n = 0, last_rel = 0, period = 0;
  logic [7:0] sh = '0;
  logic [7:0] log_b [0:15];
  logic [7:0] resp [0:1];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    p_scl <= scl_line;
    p_sda <= sda_line;
    if (!p_scl && scl_line) begin
      if (last_rel != 0) period <= cyc - last_rel;
      last_rel <= cyc;
    end
    if (p_scl && !scl_line) act_n <= act_n + 1;
    if (p_scl && scl_line && p_sda && !sda_line) begin
      active <= 1'b1; bcnt <= 0; reading <= 1'b0; byte_i <= 0; slv_low <= 1'b0;
    end else if (p_scl && scl_line && !p_sda && sda_line) begin
      active <= 1'b0; slv_low <= 1'b0;
    end else if (active) begin
      if (!p_scl && scl_line) begin
        if (bcnt < 8 && !reading) sh <= {sh[6:0], sda_line};
        if (bcnt == 8 && reading) mack <= !sda_line;
        bcnt <= bcnt + 1;
      end else if (p_scl && !scl_line) begin
        if (bcnt == 8) begin
          if (!reading) begin
            log_b[log_n[3:0]] <= sh;
            log_n <= log_n + 1;
            if (byte_i == 0) begin
              addr_ok <= (sh[7:1] == SLV); rdm <= sh[0]; slv_low <= (sh[7:1] == SLV);
            end else slv_low <= 1'b1;
          end else slv_low <= 1'b0;
        end else if (bcnt == 9) begin
          bcnt <= 0; byte_i <= byte_i + 1; slv_low <= 1'b0;
          if (byte_i == 0 && !addr_ok) active <= 1'b0;
          else if (byte_i == 0 && rdm) begin
            reading <= 1'b1; rdi <= 0; slv_low <= !resp[0][7];
          end else if (reading) begin
            if (mack && rdi == 0) begin rdi <= 1; slv_low <= !resp[1][7]; end
            else active <= 1'b0;
          end
        end else if (reading && bcnt >= 1 && bcnt <= 7)
          slv_low <= !resp[rdi][3'(7 - bcnt)];
      end
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); ra = a; wd = d; rw = 1'b1;
    @(negedge clk); rw = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); ra = a; #2; d = rdat;
  endtask

  task automatic wait_end(output logic [7:0] st);
    st = '0;
    for (int i = 0; i < 30000; i++) begin
      rd(4'd0, st);
      if ((st & 8'h0e) != 0) break;
    end
  endtask

  // expectation model from the requirements
  task automatic run_txn(input logic [2:0] p, input logic [7:0] a, input logic [7:0] c,
                         input logic [7:0] x0, input logic [7:0] x1, input string req);
    logic [7:0] eb [0:7];
    int en;
    logic ok, rdd;
    logic [7:0] st, v, e0, e1;
    @(negedge clk); log_n = 0;
    wr(4'd4, a); wr(4'd5, c); wr(4'd8, x0); wr(4'd9, x1);
    wr(4'd3, 8'h10 | {5'b0, p});
    rd(4'd2, v); chk("R4", "busy during transfer", v[1:0], 1);
    wait_end(st);
    rdd = a[0];
    ok = (a[7:1] == SLV);
    en = 0; e0 = x0; e1 = x1;
    eb[en] = (p <= 3'd1) ? a : {a[7:1], 1'b0}; en++;
    if (ok) begin
      if (p == 3'd1 && !rdd) begin eb[en] = c; en++; end
      if (p == 3'd1 && rdd) e0 = resp[0];
      if (p >= 3'd2) begin eb[en] = c; en++; end
      if ((p == 3'd2 || p == 3'd3) && !rdd) begin eb[en] = x0; en++; end
      if (p == 3'd3 && !rdd) begin eb[en] = x1; en++; end
      if (p == 3'd4) begin eb[en] = x0; en++; eb[en] = x1; en++; end
      if ((p >= 3'd2 && rdd) || p == 3'd4) begin eb[en] = {a[7:1], 1'b1}; en++; e0 = resp[0]; end
      if ((p == 3'd3 && rdd) || p == 3'd4) e1 = resp[1];
    end
    chk(ok ? req : "R10", "status", st, ok ? 8'h08 : 8'h02);
    chk(req, "byte count on bus", log_n, en);
    for (int i = 0; i < 8; i++) if (i < en) chk(req, "bus byte", log_b[i], eb[i]);
    rd(4'd8, v); chk(req, "data0", v, e0);
    rd(4'd9, v); chk(req, "data1", v, e1);
    rd(4'd2, v); chk("R4", "idle after end", v[1:0], 0);
    chk("R2", "lines released", {scl_oe, sda_oe}, 0);
    wr(4'd0, 8'h0e);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    int seed, n0;
    string tg;
    seed = $urandom(32'd2024);
    resp[0] = 8'hC5; resp[1] = 8'h3E;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 10; a++) begin rd(4'(a), v); chk("R1", "reset register", v, 0); end
    chk("R1", "reset lines", {scl_oe, sda_oe}, 0);
    // R4 control storage
    wr(4'd2, 8'hFF); rd(4'd2, v); chk("R4", "control rw bits", v, 8'hFC);
    wr(4'd2, 8'h00);
    // R11 unsupported codes
    n0 = act_n;
    wr(4'd3, 8'h15); rd(4'd0, v); chk("R11", "block code status", v, 8'h02);
    rd(4'd2, v); chk("R11", "block code not busy", v[1:0], 0);
    // R5 write-one-clear
    wr(4'd0, 8'h08); rd(4'd0, v); chk("R5", "clear other bit keeps flag", v, 8'h02);
    wr(4'd0, 8'h02); rd(4'd0, v); chk("R5", "clear flag", v, 8'h00);
    wr(4'd3, 8'h17); rd(4'd0, v); chk("R11", "code 7 status", v, 8'h02);
    chk("R11", "no bus activity", act_n - n0, 0);
    wr(4'd0, 8'hFF);
    // directed protocols
    run_txn(3'd0, {SLV, 1'b0}, 8'h00, 8'h11, 8'h22, "R6");
    run_txn(3'd1, {SLV, 1'b0}, 8'hA5, 8'h11, 8'h22, "R7");
    run_txn(3'd1, {SLV, 1'b1}, 8'hA5, 8'h11, 8'h22, "R7");
    run_txn(3'd2, {SLV, 1'b0}, 8'h4C, 8'h9D, 8'h22, "R8");
    run_txn(3'd2, {SLV, 1'b1}, 8'h4C, 8'h9D, 8'h22, "R8");
    run_txn(3'd3, {SLV, 1'b0}, 8'h10, 8'h34, 8'h12, "R8");
    run_txn(3'd3, {SLV, 1'b1}, 8'h10, 8'h34, 8'h12, "R8");
    chk("R13", "bit period", period, 4 * Q);
    run_txn(3'd4, {SLV, 1'b1}, 8'h77, 8'h01, 8'h80, "R9");
    run_txn(3'd3, 8'h20, 8'h10, 8'h34, 8'h12, "R10");
    run_txn(3'd0, 8'hFF, 8'h00, 8'h00, 8'h00, "R10");
    // R12 collision
    @(negedge clk); force_low = 1'b1;
    wr(4'd4, 8'hFE); wr(4'd3, 8'h10);
    wait_end(v);
    chk("R12", "collision status", v, 8'h04);
    rd(4'd2, v); chk("R12", "idle after collision", v[1:0], 0);
    chk("R12", "lines released", {scl_oe, sda_oe}, 0);
    @(negedge clk); force_low = 1'b0;
    wr(4'd0, 8'h0e);
    // R3 abort
    wr(4'd4, {SLV, 1'b0}); wr(4'd3, 8'h13);
    repeat (30) @(negedge clk);
    wr(4'd3, 8'h20);
    rd(4'd2, v); chk("R3", "idle after abort", v[1:0], 0);
    chk("R3", "lines after abort", {scl_oe, sda_oe}, 0);
    repeat (40) @(negedge clk);
    rd(4'd0, v); chk("R3", "no flag after abort", v, 0);
    // R2 start while busy ignored
    @(negedge clk); log_n = 0;
    wr(4'd4, {SLV, 1'b0}); wr(4'd5, 8'h61); wr(4'd8, 8'h62); wr(4'd9, 8'h63);
    wr(4'd3, 8'h13);
    repeat (50) @(negedge clk);
    wr(4'd3, 8'h10);
    wait_end(v);
    chk("R2", "status after ignored start", v, 8'h08);
    chk("R2", "word write bytes kept", log_n, 4);
    chk("R2", "last byte", log_b[3], 8'h63);
    wr(4'd0, 8'h0e);
    repeat (10) @(negedge clk);
    // random mix
    for (int k = 0; k < 30; k++) begin
      logic [2:0] p;
      logic [7:0] a;
      p = 3'($urandom_range(0, 4));
      a = ($urandom_range(0, 7) == 0) ? 8'($urandom) : {SLV, 1'($urandom)};
      resp[0] = 8'($urandom); resp[1] = 8'($urandom);
      case (p)
        3'd0: tg = "R6";
        3'd1: tg = "R7";
        3'd4: tg = "R9";
        default: tg = "R8";
      endcase
      run_txn(p, a, 8'($urandom), 8'($urandom), 8'($urandom), tg);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3800000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule